// File: doc/BRIEF.md
# Refreshing Graphic LCD Frame-Buffer Controller

This block keeps a controllerless graphic LCD panel alive. The panel holds no image of its own, so the block rescans it forever from an on-chip dual-port frame buffer. One RAM port belongs to a host, which reads and writes pixel bytes at any time. The other port belongs to a line sequencer. For each line, the sequencer pushes the line's pixels onto a narrow data bus under a divided shift clock, pulses a line latch and then waits a fixed settle time before the next line starts. It never stops and never waits for the host.

On the latch pulse of line 0 the sequencer raises a frame marker. It inverts a drive-polarity output once per frame, because a panel driven with a constant polarity gives a poor image and can be damaged. The display-on output stays low until the host enables the panel and a complete frame has been scanned after that enable. It falls at once when the enable is removed.

With the default parameters the panel is 240x64 pixels. Each byte holds eight pixels and goes out as two 4-bit nibbles, so one line takes 60 shift pulses. The buffer holds 1920 bytes, and the byte at address `line*30 + b` holds pixels `8b..8b+7` of that line.

Top module: `glcd_ctrl`

## Requirements
- R1: Lines are scanned in the order 0, 1, ..., V_LINES-1 and then again from 0. Each line sends H_PIX/NIB_W nibbles. Nibble k of line L is taken from buffer byte `L*(H_PIX/8) + k/(8/NIB_W)`, most significant nibble of each byte first. The panel takes each nibble on the falling edge of `lcd_scl_o`.
- R2: Within a line, `lcd_scl_o` is high for 2 clock cycles and then low for 2. `lcd_data_o` changes only in the cycle in which `lcd_scl_o` goes high, and it holds while `lcd_scl_o` is high.
- R3: A line has exactly H_PIX/NIB_W shift pulses. After the last one, `lcd_lp_o` is high for exactly 4 cycles, and `lcd_scl_o` stays low during that time.
- R4: `lcd_fr_o` is high only while `lcd_lp_o` is high. It is high during the latch pulse of line 0 and low during the latch pulse of every other line.
- R5: From the cycle `lcd_lp_o` falls to the cycle `lcd_scl_o` next rises, exactly SETTLE_CYC cycles pass with both signals low.
- R6: `lcd_m_o` inverts exactly once per frame, in the cycle `lcd_lp_o` falls after the last line, and it never changes at any other time.
- R7: `lcd_on_o` is high only while `disp_en_i` is high. It rises only after the scan of line 0 has started with `disp_en_i` high and that whole frame has been latched. It drops in the same cycle `disp_en_i` goes low.
- R8: A host write stores `host_wdata_i` at `host_addr_i` on the clock edge. A host read returns the byte at `host_addr_i` on `host_rdata_o` one clock later.
- R9: Host accesses never stall the scan: the rising edges of `lcd_lp_o` are always SETTLE_CYC + 4*(H_PIX/NIB_W) + 4 cycles apart. Bytes written before a line's settle interval starts appear on the panel in that line's next scan.
- R10: While `rst_ni` is low, every panel output and `lcd_on_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | AW | Host byte address |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte, one cycle latency |
| disp_en_i | input | 1 | Request to switch the panel on |
| lcd_data_o | output | NIB_W | Pixel nibble bus |
| lcd_scl_o | output | 1 | Data shift clock |
| lcd_lp_o | output | 1 | Line latch pulse |
| lcd_fr_o | output | 1 | Frame start marker |
| lcd_m_o | output | 1 | Alternating drive polarity |
| lcd_on_o | output | 1 | Panel display on |

## Verification
The scan is checked against buffer contents of all zeros, all ones, alternating 0xA5/0x5A bytes and an address-derived pattern. The uniform fills show whether shift pulses and latches happen at the right moments independent of data. The alternating and address-derived fills catch swapped nibbles, wrong byte offsets inside a line and wrong line base addresses. A further run keeps the host writing through several line periods: the line period must not move, and the final contents must reach the panel in full. The enable is raised in the middle of a frame, so the on/off output can be seen to wait out the partial frame and the full one that follows.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_LATCH  = 2'd2
  } seq_state_e;

  // shift clock is clk/4: phases 0,1 high, 2,3 low
  localparam int unsigned SCL_PHASES = 4;

endpackage

// File: rtl/glcd_dpram.sv
module glcd_dpram #(
  parameter int DEPTH = 1920,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [7:0]    a_wdata_i,
  output logic [7:0]    a_rdata_o,
  input  logic [AW-1:0] b_addr_i,
  output logic [7:0]    b_rdata_o
);

  localparam logic [AW-1:0] ADDR_MAX = AW'(DEPTH - 1);

  logic [7:0] mem_q [DEPTH];

  // port a: host, read-before-write
  always_ff @(posedge clk_i) begin
    if (a_we_i && (a_addr_i <= ADDR_MAX)) mem_q[a_addr_i] <= a_wdata_i;
    a_rdata_o <= mem_q[a_addr_i];
  end

  // port b: refresh, read only
  always_ff @(posedge clk_i) begin
    b_rdata_o <= mem_q[b_addr_i];
  end

endmodule

// File: rtl/glcd_line_seq.sv
module glcd_line_seq
  import glcd_pkg::*;
#(
  parameter int H_PIX      = 240,
  parameter int V_LINES    = 64,
  parameter int NIB_W      = 4,
  parameter int SETTLE_CYC = 64,
  parameter int AW         = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             scl_o,
  output logic             lp_o,
  output logic             fr_o,
  output logic             m_o,
  output logic [NIB_W-1:0] data_o,
  output logic             line0_start_o,
  output logic             frame_end_o
);

  localparam int BPL = H_PIX / 8;
  localparam int NPB = 8 / NIB_W;
  localparam int NPL = H_PIX / NIB_W;
  localparam int NW  = (NPL > 1) ? $clog2(NPL) : 1;
  localparam int LW  = (V_LINES > 1) ? $clog2(V_LINES) : 1;
  localparam int SW  = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  localparam logic [NW-1:0] NIB_LAST  = NW'(NPL - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(V_LINES - 1);
  localparam logic [SW-1:0] SET_INIT  = SW'(SETTLE_CYC - 1);
  localparam logic [AW-1:0] BPL_A     = AW'(BPL);

  seq_state_e       st_q;
  logic [1:0]       ph_q;
  logic [NW-1:0]    nib_q;
  logic [NW-1:0]    nxt_nib;
  logic [SW-1:0]    set_q;
  logic [LW-1:0]    line_q;
  logic [AW-1:0]    base_q;
  logic             m_q;
  logic [NIB_W-1:0] dat_q;

  function automatic logic [NIB_W-1:0] pick(input logic [7:0] b, input logic [NW-1:0] n);
    logic [7:0] sh;
    sh = b << (NIB_W * (n % NPB));
    return sh[7 -: NIB_W];
  endfunction

  // address of the byte holding the next nibble to present
  always_comb begin
    nxt_nib = '0;
    if (st_q == ST_SHIFT) nxt_nib = (nib_q == NIB_LAST) ? nib_q : nib_q + 1'b1;
  end

  assign rd_addr_o = base_q + AW'(nxt_nib / NPB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SETTLE;
      ph_q   <= '0;
      nib_q  <= '0;
      set_q  <= SET_INIT;
      line_q <= '0;
      base_q <= '0;
      m_q    <= 1'b0;
      dat_q  <= '0;
    end else begin
      case (st_q)
        ST_SETTLE: begin
          if (set_q == '0) begin
            st_q  <= ST_SHIFT;
            ph_q  <= '0;
            nib_q <= '0;
            dat_q <= pick(rd_data_i, '0);
          end else begin
            set_q <= set_q - 1'b1;
          end
        end
        ST_SHIFT: begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == 2'd3) begin
            if (nib_q == NIB_LAST) begin
              st_q <= ST_LATCH;
            end else begin
              nib_q <= nib_q + 1'b1;
              dat_q <= pick(rd_data_i, nib_q + 1'b1);
            end
          end
        end
        ST_LATCH: begin
          ph_q <= ph_q + 1'b1;
          if (ph_q == 2'd3) begin
            st_q  <= ST_SETTLE;
            set_q <= SET_INIT;
            if (line_q == LINE_LAST) begin
              line_q <= '0;
              base_q <= '0;
              m_q    <= ~m_q;
            end else begin
              line_q <= line_q + 1'b1;
              base_q <= base_q + BPL_A;
            end
          end
        end
        default: st_q <= ST_SETTLE;
      endcase
    end
  end

  assign scl_o         = (st_q == ST_SHIFT) && !ph_q[1];
  assign lp_o          = (st_q == ST_LATCH);
  assign fr_o          = lp_o && (line_q == '0);
  assign m_o           = m_q;
  assign data_o        = dat_q;
  assign line0_start_o = (st_q == ST_SETTLE) && (set_q == '0) && (line_q == '0);
  assign frame_end_o   = lp_o && (ph_q == 2'd3) && (line_q == LINE_LAST);

endmodule

// File: rtl/glcd_disp_gate.sv
module glcd_disp_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic line0_start_i,
  input  logic frame_end_i,
  output logic on_o
);

  logic armed_q;
  logic sent_q;

  // armed: a frame began with enable high; sent: that frame was completed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      sent_q  <= 1'b0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      sent_q  <= 1'b0;
    end else begin
      if (line0_start_i) armed_q <= 1'b1;
      if (frame_end_i && armed_q) sent_q <= 1'b1;
    end
  end

  assign on_o = en_i && sent_q;

endmodule

// File: rtl/glcd_ctrl.sv
module glcd_ctrl #(
  parameter  int H_PIX      = 240,
  parameter  int V_LINES    = 64,
  parameter  int NIB_W      = 4,
  parameter  int SETTLE_CYC = 64,
  localparam int DEPTH      = (H_PIX / 8) * V_LINES,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [7:0]       host_wdata_i,
  output logic [7:0]       host_rdata_o,
  input  logic             disp_en_i,
  output logic [NIB_W-1:0] lcd_data_o,
  output logic             lcd_scl_o,
  output logic             lcd_lp_o,
  output logic             lcd_fr_o,
  output logic             lcd_m_o,
  output logic             lcd_on_o
);

  logic [AW-1:0] rf_addr;
  logic [7:0]    rf_data;
  logic          line0_start;
  logic          frame_end;

  glcd_dpram #(
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_ram (
    .clk_i    (clk_i),
    .a_we_i   (host_we_i),
    .a_addr_i (host_addr_i),
    .a_wdata_i(host_wdata_i),
    .a_rdata_o(host_rdata_o),
    .b_addr_i (rf_addr),
    .b_rdata_o(rf_data)
  );

  glcd_line_seq #(
    .H_PIX     (H_PIX),
    .V_LINES   (V_LINES),
    .NIB_W     (NIB_W),
    .SETTLE_CYC(SETTLE_CYC),
    .AW        (AW)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_addr_o    (rf_addr),
    .rd_data_i    (rf_data),
    .scl_o        (lcd_scl_o),
    .lp_o         (lcd_lp_o),
    .fr_o         (lcd_fr_o),
    .m_o          (lcd_m_o),
    .data_o       (lcd_data_o),
    .line0_start_o(line0_start),
    .frame_end_o  (frame_end)
  );

  glcd_disp_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (disp_en_i),
    .line0_start_i(line0_start),
    .frame_end_i  (frame_end),
    .on_o         (lcd_on_o)
  );

endmodule

// File: rtl/glcd_ctrl_chk.sv
module glcd_ctrl_chk #(
  parameter int NIB_W      = 4,
  parameter int SETTLE_CYC = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [NIB_W-1:0] data_i,
  input logic             scl_i,
  input logic             lp_i,
  input logic             fr_i,
  input logic             m_i,
  input logic             on_i
);

  int   gap_cnt;
  logic gap_vld;

  // quiet cycles between latch end and the next shift pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_cnt <= 0;
      gap_vld <= 1'b0;
    end else if (lp_i) begin
      gap_cnt <= 0;
      gap_vld <= 1'b1;
    end else if (scl_i) begin
      gap_vld <= 1'b0;
    end else if (gap_vld) begin
      gap_cnt <= gap_cnt + 1;
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(data_i)); // R2
  AST_LATCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_i |-> !scl_i); // R3
  AST_MARK_IN_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_i |-> lp_i); // R4
  AST_SETTLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && gap_vld) |-> (gap_cnt == SETTLE_CYC)); // R5
  AST_POL_AT_LATCH_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_i != $past(m_i)) |-> ($past(lp_i) && !lp_i)); // R6
  AST_ON_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_i |-> en_i); // R7

endmodule

bind glcd_ctrl glcd_ctrl_chk #(
  .NIB_W     (NIB_W),
  .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (disp_en_i),
  .data_i(lcd_data_o),
  .scl_i (lcd_scl_o),
  .lp_i  (lcd_lp_o),
  .fr_i  (lcd_fr_o),
  .m_i   (lcd_m_o),
  .on_i  (lcd_on_o)
);

// File: tb/tb_glcd_ctrl.sv
`timescale 1ns/1ps
module tb_glcd_ctrl;

  localparam int H_PIX    = 16;
  localparam int V_LINES  = 4;
  localparam int NIB_W    = 4;
  localparam int SETTLE   = 8;
  localparam int BPL      = H_PIX / 8;
  localparam int NPB      = 8 / NIB_W;
  localparam int NPL      = H_PIX / NIB_W;
  localparam int DEPTH    = BPL * V_LINES;
  localparam int AW       = $clog2(DEPTH);
  localparam int LINE_CYC = SETTLE + 4 * NPL + 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             host_we_i = 1'b0;
  logic [AW-1:0]    host_addr_i = '0;
  logic [7:0]       host_wdata_i = '0;
  logic [7:0]       host_rdata_o;
  logic             disp_en_i = 1'b0;
  logic [NIB_W-1:0] lcd_data_o;
  logic             lcd_scl_o, lcd_lp_o, lcd_fr_o, lcd_m_o, lcd_on_o;

  always #2 clk_i = ~clk_i;

  glcd_ctrl #(
    .H_PIX(H_PIX), .V_LINES(V_LINES), .NIB_W(NIB_W), .SETTLE_CYC(SETTLE)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_we_i(host_we_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .disp_en_i(disp_en_i), .lcd_data_o(lcd_data_o),
    .lcd_scl_o(lcd_scl_o), .lcd_lp_o(lcd_lp_o), .lcd_fr_o(lcd_fr_o),
    .lcd_m_o(lcd_m_o), .lcd_on_o(lcd_on_o)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_mem [DEPTH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  function automatic int exp_nib(input int line, input int k);
    logic [7:0] b;
    b = exp_mem[line * BPL + k / NPB];
    return int'((b >> (8 - NIB_W * (k % NPB + 1))) & 8'((1 << NIB_W) - 1));
  endfunction

  // ---------------- monitor (samples at negedge) ----------------
  bit mon_en = 0;
  bit chk_en = 0;
  int cyc = 0;
  int fr_cnt = 0;
  int lpfall_cnt = 0;
  int line_cmp = 0;
  logic p_scl = 0, p_lp = 0, p_fr = 0, p_m = 0;
  logic [NIB_W-1:0] p_data = '0;
  int hi_len = 0, lo_len = 0, lp_len = 0, gap = 0, ncap = 0;
  bit gap_vld = 0, line_sync = 0, m_vld = 0, rise_vld = 0;
  int line_idx = 0, last_rise = 0;
  logic prev_m = 0;
  int cap [NPL];

  always @(negedge clk_i) begin
    cyc++;
    if (mon_en) begin
      if (lcd_fr_o) chk(lcd_lp_o, "R4 marker outside latch", lcd_lp_o, 1);
      if (lcd_m_o != p_m) chk(p_lp && !lcd_lp_o, "R6 polarity change point", lcd_lp_o, 0);
      // shift clock
      if (lcd_scl_o && !p_scl) begin
        if (gap_vld) chk(gap == SETTLE, "R5 settle length", gap, SETTLE);
        gap_vld = 0;
        if (ncap > 0) chk(lo_len == 2, "R2 scl low time", lo_len, 2);
        hi_len = 1;
      end else if (lcd_scl_o && p_scl) begin
        hi_len++;
        chk(lcd_data_o == p_data, "R2 data held while scl high", lcd_data_o, p_data);
      end else if (!lcd_scl_o && p_scl) begin
        chk(hi_len == 2, "R2 scl high time", hi_len, 2);
        if (ncap < NPL) cap[ncap] = int'(lcd_data_o);
        ncap++;
        lo_len = 1;
      end else begin
        lo_len++;
      end
      // line latch
      if (lcd_lp_o && !p_lp) begin
        chk(!lcd_scl_o, "R3 scl low in latch", lcd_scl_o, 0);
        chk(ncap == NPL, "R3 pulses per line", ncap, NPL);
        if (rise_vld) chk(cyc - last_rise == LINE_CYC, "R9 line period", cyc - last_rise, LINE_CYC);
        rise_vld = 1;
        last_rise = cyc;
        if (line_sync) begin
          line_idx = (line_idx + 1) % V_LINES;
          chk(lcd_fr_o == (line_idx == 0), "R4 marker on line 0 only", lcd_fr_o, line_idx == 0);
        end else if (lcd_fr_o) begin
          line_sync = 1;
          line_idx = 0;
        end
        if (chk_en && line_sync) begin
          for (int k = 0; k < NPL; k++) begin
            chk(cap[k] == exp_nib(line_idx, k), "R1 nibble content", cap[k], exp_nib(line_idx, k));
          end
          line_cmp++;
        end
        ncap = 0;
        lp_len = 1;
      end else if (lcd_lp_o) begin
        lp_len++;
      end else if (p_lp) begin
        chk(lp_len == 4, "R3 latch width", lp_len, 4);
        gap = 1;
        gap_vld = 1;
        lpfall_cnt++;
      end else if (gap_vld && !lcd_scl_o) begin
        gap++;
      end
      // frame marker
      if (lcd_fr_o && !p_fr) begin
        if (m_vld) chk(lcd_m_o != prev_m, "R6 polarity per frame", lcd_m_o, !prev_m);
        prev_m = lcd_m_o;
        m_vld = 1;
        fr_cnt++;
      end
    end
    p_scl = lcd_scl_o; p_lp = lcd_lp_o; p_fr = lcd_fr_o; p_m = lcd_m_o; p_data = lcd_data_o;
  end

  // ---------------- helpers ----------------
  task automatic wait_fr();
    int f0;
    f0 = fr_cnt;
    while (fr_cnt == f0) @(negedge clk_i);
  endtask

  task automatic wait_lpfall();
    int l0;
    l0 = lpfall_cnt;
    while (lpfall_cnt == l0) @(negedge clk_i);
  endtask

  task automatic host_wr(input int a, input logic [7:0] d);
    @(posedge clk_i); #1;
    host_we_i = 1'b1; host_addr_i = AW'(a); host_wdata_i = d;
    exp_mem[a] = d;
    @(posedge clk_i); #1;
    host_we_i = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      chk({lcd_scl_o, lcd_lp_o, lcd_fr_o, lcd_m_o, lcd_on_o} == 5'b0, "R10 outputs in reset",
          int'({lcd_scl_o, lcd_lp_o, lcd_fr_o, lcd_m_o, lcd_on_o}), 0);
      chk(lcd_data_o == '0, "R10 data in reset", lcd_data_o, 0);
    end
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    mon_en = 1;
  endtask

  task automatic t_fill(input int kind);
    int c0;
    chk_en = 0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] d;
      case (kind)
        0: d = 8'h00;
        1: d = 8'hFF;
        2: d = (a % 2 == 0) ? 8'hA5 : 8'h5A;
        default: d = 8'(a * 37 + 11);
      endcase
      host_wr(a, d);
    end
    wait_lpfall();
    chk_en = 1;
    c0 = line_cmp;
    wait_fr(); wait_fr();
    chk(line_cmp - c0 >= V_LINES, "R1 lines compared", line_cmp - c0, V_LINES);
    chk(lcd_on_o == 1'b0, "R7 off while disabled", lcd_on_o, 0);
  endtask

  task automatic t_read();
    host_wr(3, 8'h3C);
    host_wr(DEPTH - 1, 8'hC3);
    @(posedge clk_i); #1; host_addr_i = AW'(3);
    @(posedge clk_i); @(negedge clk_i);
    chk(host_rdata_o == 8'h3C, "R8 read latency", host_rdata_o, 8'h3C);
    @(posedge clk_i); #1; host_addr_i = AW'(DEPTH - 1);
    @(posedge clk_i); @(negedge clk_i);
    chk(host_rdata_o == 8'hC3, "R8 read last byte", host_rdata_o, 8'hC3);
  endtask

  task automatic t_live_write();
    int c0;
    chk_en = 0;
    for (int r = 0; r < 3 * LINE_CYC; r++) begin
      @(posedge clk_i); #1;
      host_we_i = 1'b1;
      host_addr_i = AW'(r % DEPTH);
      host_wdata_i = 8'(r * 13 + 7);
      exp_mem[r % DEPTH] = 8'(r * 13 + 7);
    end
    @(posedge clk_i); #1;
    host_we_i = 1'b0;
    wait_lpfall();
    chk_en = 1;
    c0 = line_cmp;
    wait_fr(); wait_fr();
    chk(line_cmp - c0 >= V_LINES, "R9 lines after live writes", line_cmp - c0, V_LINES);
  endtask

  task automatic t_onoff();
    chk(lcd_on_o == 1'b0, "R7 off before enable", lcd_on_o, 0);
    wait_fr();
    wait_lpfall();
    @(posedge clk_i); #1; disp_en_i = 1'b1;
    @(negedge clk_i);
    chk(lcd_on_o == 1'b0, "R7 not on at enable", lcd_on_o, 0);
    wait_fr();
    chk(lcd_on_o == 1'b0, "R7 partial frame ignored", lcd_on_o, 0);
    wait_fr();
    chk(lcd_on_o == 1'b1, "R7 on after full frame", lcd_on_o, 1);
    @(posedge clk_i); #1; disp_en_i = 1'b0;
    @(negedge clk_i);
    chk(lcd_on_o == 1'b0, "R7 drop with enable", lcd_on_o, 0);
    @(posedge clk_i); #1; disp_en_i = 1'b1;
    @(negedge clk_i);
    chk(lcd_on_o == 1'b0, "R7 re-enable waits", lcd_on_o, 0);
    disp_en_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_fill(0);
    t_fill(1);
    t_fill(2);
    t_fill(3);
    t_read();
    t_live_write();
    t_onoff();
    repeat (10) @(negedge clk_i);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
    $finish;
  end

endmodule